// File: doc/BRIEF.md
# Pipelined Radix-2 Frequency-Decimation Butterfly

This block is the arithmetic core of one stage of a decimation-in-frequency FFT. Each accepted transfer carries two complex operands `a` and `b` and one complex twiddle `w`. The block returns two results. The first is the plain sum `a + b`. The second is the difference `a - b` rotated by the twiddle. The twiddle uses a fixed-point scale in which 2^(CW-2) stands for 1.0. With this scale a rotation cannot push the result past the output width.

The complex rotation uses three real products instead of four. Each product is formed by a pipelined shift-and-add multiplier that spends one register stage per bit of its iterated operand. The sum branch is held in a matching delay line and carries the same 2^(CW-2) scale. Both results then pass through a shared round-to-nearest stage, so every path shares one fixed latency. A one-bit marker (`in_sync`) rides through the pipeline with its transfer. It flags, for example, the first pair of a transform.

Both data sides use valid/ready. The whole pipeline advances on a clock only when `out_ready` is high, and `in_ready` is the same signal as `out_ready`. Back-pressure therefore freezes every stage at once. A cycle with `in_valid` low on an advancing clock becomes an empty slot that leaves the block exactly LAT advancing clocks later.

Top module: `radix2_dif_butterfly`

## Requirements
- R1: `out_sum_re`/`out_sum_im` equal `in_a_re + in_b_re` and `in_a_im + in_b_im` of the same transfer. The values are exact and sign-extended to OW bits.
- R2: `out_dif_re`/`out_dif_im` equal round(P / 2^(CW-2)), where P_re = dr*wr - di*wi and P_im = dr*wi + di*wr, with d = a - b. The rounding is floor((P + 2^(CW-3)) / 2^(CW-2)), so ties round upward.
- R3: The result of a transfer becomes visible after exactly LAT = CW + 4 advancing clocks. The accepting clock counts as the first of them.
- R4: `out_sync` is 1 exactly on the outputs of transfers accepted with `in_sync` = 1, and it is never 1 while `out_valid` is 0.
- R5: `in_ready` always equals `out_ready`. On a clock with `out_ready` low, no transfer is accepted, and `out_valid` and all result ports hold their values.
- R6: Transfers leave in acceptance order. A clock that advances without an accepted transfer yields exactly one clock with `out_valid` low, LAT advancing clocks later, and no result is lost or repeated.
- R7: A synchronous `rst` clears `out_valid` and `out_sync` on the next clock regardless of `out_ready`, and discards every transfer in flight.
- R8: With OW = IW + 2 and twiddle components within ±2^(CW-2), full-scale operands (including -2^(IW-1)) and unit twiddles along both axes give exact results without wrap-around.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input transfer valid |
| in_ready | output | 1 | Input accepted when high together with in_valid (equals out_ready) |
| in_sync | input | 1 | Marker carried with the transfer |
| in_a_re | input | IW | Operand a, real part, two's complement |
| in_a_im | input | IW | Operand a, imaginary part |
| in_b_re | input | IW | Operand b, real part |
| in_b_im | input | IW | Operand b, imaginary part |
| in_w_re | input | CW | Twiddle real part, 1.0 = 2^(CW-2) |
| in_w_im | input | CW | Twiddle imaginary part, 1.0 = 2^(CW-2) |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Downstream ready; advances the pipeline |
| out_sync | output | 1 | Marker of the presented result |
| out_sum_re | output | OW | Sum, real part |
| out_sum_im | output | OW | Sum, imaginary part |
| out_dif_re | output | OW | Rotated difference, real part |
| out_dif_im | output | OW | Rotated difference, imaginary part |

## Verification
Back-pressure and marker transport can fall on the same cycle. The bench makes this happen by marking every eighth accepted transfer while it drops `out_ready` at random. A marked result is then often held on the outputs for several clocks. Each held cycle is judged against the previously presented values. After release, the result and its marker are compared with the reference queue entry, and the advancing-clock count since acceptance must equal LAT minus one. A reset applied while marked transfers are in flight is judged the same way: the flushed entries must never appear.

// File: rtl/bfly_pkg.sv
package bfly_pkg;
  // Indices of the three real products of the rotation.
  localparam int PROD_A = 0;  // wr * (dr + di)
  localparam int PROD_B = 1;  // dr * (wi - wr)
  localparam int PROD_C = 2;  // di * (wr + wi)
  localparam int NPROD  = 3;

  // Input register + one stage per multiplier bit (CW+1) + combine + round.
  function automatic int bfly_latency(input int coef_w);
    return coef_w + 4;
  endfunction
endpackage

// File: rtl/bfly_delay.sv
module bfly_delay #(
  parameter int W   = 1,
  parameter int D   = 1,
  parameter bit CLR = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] pipe [D];

  always_ff @(posedge clk) begin
    if (CLR && rst) begin
      for (int i = 0; i < D; i++) pipe[i] <= '0;
    end else if (en) begin
      pipe[0] <= d_i;
      for (int i = 1; i < D; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q_o = pipe[D-1];
endmodule

// File: rtl/bfly_presum.sv
module bfly_presum
  import bfly_pkg::*;
#(
  parameter int IW = 8,
  parameter int CW = 8
) (
  input  logic                 clk,
  input  logic                 en,
  input  logic signed [IW-1:0] a_re,
  input  logic signed [IW-1:0] a_im,
  input  logic signed [IW-1:0] b_re,
  input  logic signed [IW-1:0] b_im,
  input  logic signed [CW-1:0] w_re,
  input  logic signed [CW-1:0] w_im,
  output logic signed [IW:0]   sum_re,
  output logic signed [IW:0]   sum_im,
  output logic signed [IW+1:0] mx [NPROD],
  output logic signed [CW:0]   my [NPROD]
);
  localparam int DW = IW + 1;
  localparam int AW = IW + 2;
  localparam int BW = CW + 1;

  logic signed [DW-1:0] d_re, d_im;

  always_comb begin
    d_re = DW'(a_re) - DW'(b_re);
    d_im = DW'(a_im) - DW'(b_im);
  end

  always_ff @(posedge clk) begin
    if (en) begin
      sum_re     <= DW'(a_re) + DW'(b_re);
      sum_im     <= DW'(a_im) + DW'(b_im);
      mx[PROD_A] <= AW'(d_re) + AW'(d_im);
      my[PROD_A] <= BW'(w_re);
      mx[PROD_B] <= AW'(d_re);
      my[PROD_B] <= BW'(w_im) - BW'(w_re);
      mx[PROD_C] <= AW'(d_im);
      my[PROD_C] <= BW'(w_re) + BW'(w_im);
    end
  end
endmodule

// File: rtl/bfly_sa_mult.sv
module bfly_sa_mult #(
  parameter int AW = 10,
  parameter int BW = 9
) (
  input  logic                    clk,
  input  logic                    en,
  input  logic signed [AW-1:0]    a_i,
  input  logic signed [BW-1:0]    b_i,
  output logic signed [AW+BW-1:0] p_o
);
  localparam int PW = AW + BW;

  // One register stage per bit of b; the top bit carries negative weight.
  for (genvar j = 0; j < BW; j++) begin : g_st
    localparam int RW = BW - j;
    logic signed [PW-1:0] acc_in, term, acc_q;
    logic signed [AW-1:0] a_in;
    logic [RW-1:0]        b_in;

    if (j == 0) begin : g_head
      assign acc_in = '0;
      assign a_in   = a_i;
      assign b_in   = b_i;
    end else begin : g_body
      assign acc_in = g_st[j-1].acc_q;
      assign a_in   = g_st[j-1].g_keep.a_q;
      assign b_in   = g_st[j-1].g_keep.b_q;
    end

    assign term = b_in[0] ? (PW'(a_in) <<< j) : '0;

    always_ff @(posedge clk) begin
      if (en) begin
        if (j == BW - 1) acc_q <= acc_in - term;
        else             acc_q <= acc_in + term;
      end
    end

    if (j < BW - 1) begin : g_keep
      logic signed [AW-1:0] a_q;
      logic [RW-2:0]        b_q;
      always_ff @(posedge clk) begin
        if (en) begin
          a_q <= a_in;
          b_q <= b_in[RW-1:1];
        end
      end
    end
  end

  assign p_o = g_st[BW-1].acc_q;
endmodule

// File: rtl/bfly_post.sv
module bfly_post
  import bfly_pkg::*;
#(
  parameter int IW = 8,
  parameter int CW = 8,
  parameter int OW = 10
) (
  input  logic                    clk,
  input  logic                    en,
  input  logic signed [IW+CW+2:0] prod_i [NPROD],
  input  logic signed [IW:0]      sum_re_i,
  input  logic signed [IW:0]      sum_im_i,
  output logic signed [OW-1:0]    sum_re_o,
  output logic signed [OW-1:0]    sum_im_o,
  output logic signed [OW-1:0]    dif_re_o,
  output logic signed [OW-1:0]    dif_im_o
);
  localparam int PW = IW + CW + 3;
  localparam int XW = PW + 1;
  localparam int SH = CW - 2;
  localparam logic signed [XW-1:0] HALF = XW'(1) <<< (SH - 1);

  logic signed [XW-1:0] sre_q, sim_q, dre_q, dim_q;

  // Combine: sum branch brought to the product scale.
  always_ff @(posedge clk) begin
    if (en) begin
      dre_q <= XW'(prod_i[PROD_A]) - XW'(prod_i[PROD_C]);
      dim_q <= XW'(prod_i[PROD_A]) + XW'(prod_i[PROD_B]);
      sre_q <= XW'(sum_re_i) <<< SH;
      sim_q <= XW'(sum_im_i) <<< SH;
    end
  end

  // Round to nearest (ties up) and drop the twiddle scale.
  always_ff @(posedge clk) begin
    if (en) begin
      sum_re_o <= OW'((sre_q + HALF) >>> SH);
      sum_im_o <= OW'((sim_q + HALF) >>> SH);
      dif_re_o <= OW'((dre_q + HALF) >>> SH);
      dif_im_o <= OW'((dim_q + HALF) >>> SH);
    end
  end
endmodule

// File: rtl/radix2_dif_butterfly.sv
module radix2_dif_butterfly
  import bfly_pkg::*;
#(
  parameter int IW = 8,
  parameter int CW = 8,
  parameter int OW = IW + 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic                 in_sync,
  input  logic signed [IW-1:0] in_a_re,
  input  logic signed [IW-1:0] in_a_im,
  input  logic signed [IW-1:0] in_b_re,
  input  logic signed [IW-1:0] in_b_im,
  input  logic signed [CW-1:0] in_w_re,
  input  logic signed [CW-1:0] in_w_im,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic                 out_sync,
  output logic signed [OW-1:0] out_sum_re,
  output logic signed [OW-1:0] out_sum_im,
  output logic signed [OW-1:0] out_dif_re,
  output logic signed [OW-1:0] out_dif_im
);
  localparam int DW  = IW + 1;
  localparam int AW  = IW + 2;
  localparam int BW  = CW + 1;
  localparam int PW  = AW + BW;
  localparam int LAT = bfly_latency(CW);

  logic advance;
  assign advance  = out_ready;
  assign in_ready = out_ready;

  logic signed [DW-1:0] s_re, s_im;
  logic signed [AW-1:0] mx [NPROD];
  logic signed [BW-1:0] my [NPROD];
  logic signed [PW-1:0] prod [NPROD];

  bfly_presum #(.IW(IW), .CW(CW)) u_presum (
    .clk(clk), .en(advance),
    .a_re(in_a_re), .a_im(in_a_im), .b_re(in_b_re), .b_im(in_b_im),
    .w_re(in_w_re), .w_im(in_w_im),
    .sum_re(s_re), .sum_im(s_im), .mx(mx), .my(my)
  );

  for (genvar k = 0; k < NPROD; k++) begin : g_mul
    bfly_sa_mult #(.AW(AW), .BW(BW)) u_mult (
      .clk(clk), .en(advance), .a_i(mx[k]), .b_i(my[k]), .p_o(prod[k])
    );
  end

  logic [2*DW-1:0] sum_dly;
  bfly_delay #(.W(2*DW), .D(BW), .CLR(1'b0)) u_sum_dly (
    .clk(clk), .rst(rst), .en(advance),
    .d_i({s_re, s_im}), .q_o(sum_dly)
  );

  logic [1:0] ctrl_q;
  bfly_delay #(.W(2), .D(LAT), .CLR(1'b1)) u_ctrl_dly (
    .clk(clk), .rst(rst), .en(advance),
    .d_i({in_valid, in_valid & in_sync}), .q_o(ctrl_q)
  );
  assign out_valid = ctrl_q[1];
  assign out_sync  = ctrl_q[0];

  bfly_post #(.IW(IW), .CW(CW), .OW(OW)) u_post (
    .clk(clk), .en(advance), .prod_i(prod),
    .sum_re_i($signed(sum_dly[2*DW-1:DW])), .sum_im_i($signed(sum_dly[DW-1:0])),
    .sum_re_o(out_sum_re), .sum_im_o(out_sum_im),
    .dif_re_o(out_dif_re), .dif_im_o(out_dif_im)
  );
endmodule

// File: rtl/radix2_dif_butterfly_chk.sv
module radix2_dif_butterfly_chk
  import bfly_pkg::*;
#(
  parameter int IW = 8,
  parameter int CW = 8,
  parameter int OW = IW + 2
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 in_valid,
  input logic                 in_ready,
  input logic signed [IW-1:0] in_a_re,
  input logic signed [IW-1:0] in_b_re,
  input logic                 out_valid,
  input logic                 out_ready,
  input logic                 out_sync,
  input logic signed [OW-1:0] out_sum_re,
  input logic signed [OW-1:0] out_sum_im,
  input logic signed [OW-1:0] out_dif_re,
  input logic signed [OW-1:0] out_dif_im
);
  localparam int LAT = bfly_latency(CW);

  logic signed [OW-1:0] exp_sum [LAT];
  always_ff @(posedge clk) begin
    if (out_ready) begin
      exp_sum[0] <= OW'(in_a_re) + OW'(in_b_re);
      for (int i = 1; i < LAT; i++) exp_sum[i] <= exp_sum[i-1];
    end
  end

  int inflight;
  always_ff @(posedge clk) begin
    if (rst) inflight <= 0;
    else inflight <= inflight + int'(in_valid && in_ready) - int'(out_valid && out_ready);
  end

  a_r7_reset_clears: assert property (@(posedge clk)
    rst |=> (!out_valid && !out_sync));

  a_r4_sync_needs_valid: assert property (@(posedge clk) disable iff (rst)
    out_sync |-> out_valid);

  a_r5_hold_on_stall: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_sum_re) && $stable(out_sum_im)
                                   && $stable(out_dif_re) && $stable(out_dif_im)));

  a_r3_inflight_bound: assert property (@(posedge clk) disable iff (rst)
    (inflight >= 0) && (inflight <= LAT));

  a_r1_sum_tracks_input: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_sum_re == exp_sum[LAT-1]));
endmodule

bind radix2_dif_butterfly radix2_dif_butterfly_chk #(.IW(IW), .CW(CW), .OW(OW)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .in_a_re(in_a_re), .in_b_re(in_b_re),
  .out_valid(out_valid), .out_ready(out_ready), .out_sync(out_sync),
  .out_sum_re(out_sum_re), .out_sum_im(out_sum_im),
  .out_dif_re(out_dif_re), .out_dif_im(out_dif_im)
);

// File: tb/test_radix2_dif_butterfly.sv
`timescale 1ns/1ps
module test_radix2_dif_butterfly;
  localparam int IW  = 8;
  localparam int CW  = 8;
  localparam int OW  = IW + 2;
  localparam int LAT = CW + 4;   // R3
  localparam longint UNIT = longint'(1) <<< (CW - 2);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, in_sync = 1'b0, out_ready = 1'b1;
  logic in_ready, out_valid, out_sync;
  logic signed [IW-1:0] in_a_re = '0, in_a_im = '0, in_b_re = '0, in_b_im = '0;
  logic signed [CW-1:0] in_w_re = '0, in_w_im = '0;
  logic signed [OW-1:0] out_sum_re, out_sum_im, out_dif_re, out_dif_im;

  always #2 clk = ~clk;  // 250 MHz

  radix2_dif_butterfly #(.IW(IW), .CW(CW), .OW(OW)) i_radix2_dif_butterfly (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_sync(in_sync),
    .in_a_re(in_a_re), .in_a_im(in_a_im), .in_b_re(in_b_re), .in_b_im(in_b_im),
    .in_w_re(in_w_re), .in_w_im(in_w_im),
    .out_valid(out_valid), .out_ready(out_ready), .out_sync(out_sync),
    .out_sum_re(out_sum_re), .out_sum_im(out_sum_im),
    .out_dif_re(out_dif_re), .out_dif_im(out_dif_im)
  );

  typedef struct {
    longint sre, sim, dre, dim;
    bit     sync;
    longint stamp;
    string  tag;
  } exp_t;

  exp_t   q[$];
  int     n_chk = 0, n_fail = 0;
  longint adv_cnt = 0;
  longint p_sre, p_sim, p_dre, p_dim;
  int     sync_every = 0;

  task automatic check(input string req, input longint act, input longint expv);
    n_chk++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, expv, $time);
    end
  endtask

  function automatic longint rnd(input longint x);
    return (x + (UNIT >>> 1)) >>> (CW - 2);
  endfunction

  // Reference model of one accepted transfer.
  function automatic exp_t model(input longint ar, ai, br, bi, wr, wi, input bit s, input string tag);
    exp_t e;
    longint dr, di;
    dr = ar - br;
    di = ai - bi;
    e.sre = ar + br;
    e.sim = ai + bi;
    e.dre = rnd(dr * wr - di * wi);
    e.dim = rnd(dr * wi + di * wr);
    e.sync = s;
    e.stamp = adv_cnt;
    e.tag = tag;
    return e;
  endfunction

  string cur_tag = "R2";

  // Observe one clock: called at the falling edge, before new stimulus.
  task automatic tick();
    @(negedge clk);
    if (rst) begin
      q.delete();
    end else if (out_ready) begin
      adv_cnt++;
      if (in_valid)
        q.push_back(model(in_a_re, in_a_im, in_b_re, in_b_im, in_w_re, in_w_im, in_sync, cur_tag));
      if (out_valid) begin
        if (q.size() == 0) begin
          check("R6 unexpected output", 1, 0);
        end else begin
          exp_t e;
          e = q.pop_front();
          check("R1 sum re", out_sum_re, e.sre);
          check("R1 sum im", out_sum_im, e.sim);
          check({e.tag, " dif re"}, out_dif_re, e.dre);
          check({e.tag, " dif im"}, out_dif_im, e.dim);
          check("R4 sync", out_sync, e.sync);
          check("R3 latency", adv_cnt - e.stamp, LAT - 1);
        end
      end else begin
        check("R4 sync without valid", out_sync, 0);
        if (q.size() > 0) check("R6 result overdue", (adv_cnt - q[0].stamp >= LAT - 1) ? 1 : 0, 0);
      end
    end else begin
      check("R5 in_ready follows out_ready", in_ready, 0);
      if (out_valid) begin
        check("R5 hold sum re", out_sum_re, p_sre);
        check("R5 hold sum im", out_sum_im, p_sim);
        check("R5 hold dif re", out_dif_re, p_dre);
        check("R5 hold dif im", out_dif_im, p_dim);
      end
    end
    p_sre = out_sum_re; p_sim = out_sum_im; p_dre = out_dif_re; p_dim = out_dif_im;
  endtask

  task automatic drive(input longint ar, ai, br, bi, wr, wi, input bit s);
    in_valid = 1'b1;
    in_sync  = s;
    in_a_re = IW'(ar); in_a_im = IW'(ai); in_b_re = IW'(br); in_b_im = IW'(bi);
    in_w_re = CW'(wr); in_w_im = CW'(wi);
  endtask

  task automatic drive_random();
    longint lim;
    lim = longint'(1) <<< (IW - 1);
    if ($urandom_range(3) != 0) begin
      bit s;
      sync_every++;
      s = (sync_every % 8) == 0;
      drive(longint'($urandom_range(2*lim - 1)) - lim, longint'($urandom_range(2*lim - 1)) - lim,
            longint'($urandom_range(2*lim - 1)) - lim, longint'($urandom_range(2*lim - 1)) - lim,
            longint'($urandom_range(2*UNIT)) - UNIT, longint'($urandom_range(2*UNIT)) - UNIT, s);
    end else begin
      in_valid = 1'b0;
      in_sync  = 1'b0;
    end
    out_ready = ($urandom_range(4) != 0);
  endtask

  initial begin : main
    longint mx, mn;
    mx = (longint'(1) <<< (IW - 1)) - 1;
    mn = -(longint'(1) <<< (IW - 1));

    // Reset state (R7)
    rst = 1'b1; out_ready = 1'b1; in_valid = 1'b0;
    for (int i = 0; i < 3; i++) tick();
    check("R7 reset out_valid", out_valid, 0);
    check("R7 reset out_sync", out_sync, 0);
    check("R5 in_ready equals out_ready", in_ready, out_ready);
    rst = 1'b0;

    // Full-scale corners and unit twiddles (R8), rounding ties (R2)
    cur_tag = "R8";
    tick(); drive(mn, mn, mn, mn, UNIT, 0, 1'b1);
    tick(); drive(mx, mn, mn, mx, UNIT, 0, 1'b0);
    tick(); drive(mx, mn, mn, mx, 0, UNIT, 1'b0);
    tick(); drive(mx, mn, mn, mx, -UNIT, 0, 1'b0);
    tick(); drive(mx, mn, mn, mx, 0, -UNIT, 1'b0);
    tick(); drive(mx, mn, mn, mx, UNIT, UNIT, 1'b0);
    tick(); drive(mn, mx, mx, mn, -UNIT, -UNIT, 1'b1);
    tick(); cur_tag = "R2"; drive(1, 0, 0, 0, UNIT / 2, 0, 1'b0);
    tick(); drive(0, 0, 1, 0, UNIT / 2, 0, 1'b0);
    tick(); drive(3, 0, 0, 0, UNIT / 2, 0, 1'b0);
    tick(); drive(0, 1, 0, 0, 0, -(UNIT / 2), 1'b0);
    tick(); in_valid = 1'b0; in_sync = 1'b0;
    for (int i = 0; i < LAT + 2; i++) tick();
    check("R6 corner queue drained", q.size(), 0);

    // Random stream with bubbles and stalls (R1..R6)
    for (int i = 0; i < 1500; i++) begin
      tick();
      drive_random();
    end

    // Reset while transfers are in flight (R7)
    tick(); rst = 1'b1; out_ready = 1'b0; in_valid = 1'b1;
    tick();
    check("R7 reset under stall clears out_valid", out_valid, 0);
    check("R7 reset under stall clears out_sync", out_sync, 0);
    rst = 1'b0; out_ready = 1'b1; in_valid = 1'b0;
    for (int i = 0; i < LAT + 2; i++) begin
      tick();
      check("R7 flushed transfers never appear", out_valid, 0);
    end

    for (int i = 0; i < 400; i++) begin
      tick();
      drive_random();
    end

    // Drain: every accepted transfer must come out (R6)
    tick(); in_valid = 1'b0; in_sync = 1'b0; out_ready = 1'b1;
    for (int i = 0; i < LAT + 3; i++) tick();
    check("R6 final queue drained", q.size(), 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : watchdog
    #(4 * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule